// File: doc/BRIEF.md
# Clocked Serial Transfer Engine

This block is the master-side core of a synchronous serial port. The host places a word of up to nine bits into a single transmit holding register. The engine moves that word into a shift register and sends it least significant bit first on a serial data line, with a serial clock that it generates itself. A separate bit-rate tick input paces the clock. Each tick is one half of a bit time. On the same clock edges, the engine samples the serial input line and assembles the received word in a single receive holding register.

The word length is selected by a 3-bit code. Between back-to-back words the engine can hold the clock for 0 to 3 idle bit times. A slave-select input forces that pause to zero. The transmit side reports two separate flags: one says the holding register is free, and the other says the line has gone quiet. The receive side reports a full flag, an overrun flag and an interrupt. A force-high command drives the data line high. A soft reset aborts any transfer in progress.

Top module: `csx_engine`

## Requirements
- R1: The length code `cfg_len` is sampled when a word is taken for shifting. The codes are 3'b000 = 8 bits, 3'b001 = 5, 3'b010 = 6, 3'b011 = 7 and 3'b100 = 9. The remaining codes act as 8 bits.
- R2: `sclk` idles high and changes only in the cycle after a `bit_tick`. Each bit takes two ticks. `sdo` changes on the falling edge of `sclk`, and `sdi` is sampled on the rising edge. Bits go out and come in least significant bit first.
- R3: A received word sits right-aligned in `rx_data`, and every bit above the selected length reads 0.
- R4: The 2-bit `cfg_wait` value w sets the gap between words. From the last rising `sclk` edge of one word to the first falling edge of the next, there are 2w+1 ticks. With w = 0 the clock runs without a break.
- R5: While `cfg_slave` is 1, the gap behaves as w = 0 whatever `cfg_wait` holds.
- R6: `tx_empty` goes to 0 on an accepted `tx_wr` and returns to 1 when the word moves into the shift register. A `tx_wr` while `tx_empty` is 0 is ignored, and that word never appears on `sdo`.
- R7: `bus_idle` goes to 0 on an accepted write. It returns to 1 only once `tx_empty` is 1 and neither shifting nor a gap is in progress.
- R8: `rx_full` is set when a word completes and cleared by `rx_rd`. `rx_irq` is 1 exactly when `rx_full` and `irq_en` are both 1.
- R9: If a word completes while `rx_full` is 1 and no read occurs in that cycle, `overrun` is set and `rx_data` keeps the older word.
- R10: A `force_high` pulse drives `sdo` to 1 in the next cycle.
- R11: `soft_rst` aborts any transfer. In the next cycle `sclk` = 1, `tx_empty` = 1, `bus_idle` = 1 and `overrun` = 0. The receive data and `rx_full` are left untouched.
- R12: After `rst`, the outputs are `sclk` = 1, `sdo` = 1, `tx_empty` = 1, `bus_idle` = 1, `rx_full` = 0, `overrun` = 0, `rx_irq` = 0 and `rx_data` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_tick | input | 1 | Half-bit pacing pulse, one cycle wide |
| cfg_len | input | 3 | Word length code |
| cfg_wait | input | 2 | Idle bit times between words |
| cfg_slave | input | 1 | Forces the inter-word gap to zero |
| irq_en | input | 1 | Receive interrupt enable |
| soft_rst | input | 1 | Abort transfer, reset transmit flags and overrun |
| force_high | input | 1 | Drive serial output high |
| tx_wr | input | 1 | Write strobe for transmit data |
| tx_data | input | 9 | Transmit word |
| rx_rd | input | 1 | Read strobe, clears the full flag |
| rx_data | output | 9 | Received word, right-aligned |
| tx_empty | output | 1 | Transmit holding register free |
| bus_idle | output | 1 | No transfer or gap in progress |
| rx_full | output | 1 | Receive holding register holds a word |
| overrun | output | 1 | A word arrived while the register was full |
| rx_irq | output | 1 | Receive interrupt |
| sclk | output | 1 | Serial clock, idles high |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A bit counter that is off by one, or a length decode that is wrong, shows up within the same word. The serial stream then carries one bit too many or too few, and the next word's bits fall out of line. The received word also gains a stray upper bit or loses its top bit as soon as `rx_full` rises. A gap counter that loads the wrong value shows only at the boundary between two queued words, as a rise-to-fall interval that is too long or too short. Flag mistakes that break the split between the holding register and the line show in the cycle after the word is loaded: `tx_empty` must rise while `bus_idle` stays low until the final rising edge.

// File: rtl/csx_pkg.sv
package csx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_GAP   = 2'd2
  } csx_state_e;

  // Word length in bits for a length code; unlisted codes fall back to 8.
  function automatic logic [3:0] csx_len_decode(input logic [2:0] code);
    case (code)
      3'b001:  return 4'd5;
      3'b010:  return 4'd6;
      3'b011:  return 4'd7;
      3'b100:  return 4'd9;
      default: return 4'd8;
    endcase
  endfunction

endpackage

// File: rtl/csx_tx_hold.sv
module csx_tx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              load,
  input  logic              busy,
  output logic [DATA_W-1:0] hold_data,
  output logic              tx_empty,
  output logic              bus_idle
);

  logic wr_accept;
  assign wr_accept = wr_en && tx_empty;

  always_ff @(posedge clk) begin
    if (rst || soft_rst) begin
      hold_data <= '1;
      tx_empty  <= 1'b1;
      bus_idle  <= 1'b1;
    end else if (wr_accept) begin
      hold_data <= wr_data;
      tx_empty  <= 1'b0;
      bus_idle  <= 1'b0;
    end else begin
      if (load) begin
        tx_empty <= 1'b1;
      end
      if (tx_empty && !busy) begin
        bus_idle <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/csx_shift_eng.sv
module csx_shift_eng
  import csx_pkg::*;
#(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              bit_tick,
  input  logic [2:0]        cfg_len,
  input  logic [1:0]        cfg_wait,
  input  logic              cfg_slave,
  input  logic              force_high,
  input  logic              hold_valid,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              sdi,
  output logic              load,
  output logic              busy,
  output logic              sclk,
  output logic              sdo,
  output logic              word_done,
  output logic [DATA_W-1:0] word_data
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  csx_state_e        state;
  logic              phase;
  logic [CNT_W-1:0]  bit_idx;
  logic [CNT_W-1:0]  len_q;
  logic [1:0]        wait_q;
  logic [2:0]        gap_cnt;
  logic [DATA_W-1:0] tx_sh;
  logic [DATA_W-1:0] rx_sh;
  logic [DATA_W-1:0] rx_nxt;
  logic              last_bit;
  logic              rise_tick;
  logic              gap_end;
  logic [1:0]        eff_wait;

  assign last_bit  = (bit_idx == len_q - CNT_W'(1));
  assign rise_tick = (state == ST_SHIFT) && bit_tick && phase;
  assign gap_end   = (state == ST_GAP) && bit_tick && (gap_cnt == 3'd1);
  assign eff_wait  = cfg_slave ? 2'd0 : cfg_wait;
  assign busy      = (state != ST_IDLE);
  assign rx_nxt    = rx_sh | ({{(DATA_W-1){1'b0}}, sdi} << bit_idx);

  always_comb begin
    load = 1'b0;
    if (!soft_rst && hold_valid) begin
      if (state == ST_IDLE) begin
        load = 1'b1;
      end else if (rise_tick && last_bit && (wait_q == 2'd0)) begin
        load = 1'b1;
      end else if (gap_end) begin
        load = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      bit_idx   <= '0;
      len_q     <= CNT_W'(8);
      wait_q    <= 2'd0;
      gap_cnt   <= 3'd0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      sclk      <= 1'b1;
      sdo       <= 1'b1;
      word_done <= 1'b0;
      word_data <= '0;
    end else if (soft_rst) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      bit_idx   <= '0;
      sclk      <= 1'b1;
      word_done <= 1'b0;
      if (force_high) begin
        sdo <= 1'b1;
      end
    end else begin
      word_done <= 1'b0;
      if (bit_tick) begin
        case (state)
          ST_SHIFT: begin
            if (!phase) begin
              sclk  <= 1'b0;
              sdo   <= tx_sh[0];
              phase <= 1'b1;
            end else begin
              sclk  <= 1'b1;
              phase <= 1'b0;
              rx_sh <= rx_nxt;
              tx_sh <= tx_sh >> 1;
              if (last_bit) begin
                word_done <= 1'b1;
                word_data <= rx_nxt;
                if (wait_q != 2'd0) begin
                  state   <= ST_GAP;
                  gap_cnt <= {wait_q, 1'b0};
                end else begin
                  state <= ST_IDLE;
                end
              end else begin
                bit_idx <= bit_idx + CNT_W'(1);
              end
            end
          end
          ST_GAP: begin
            if (gap_cnt == 3'd1) begin
              state <= ST_IDLE;
            end else begin
              gap_cnt <= gap_cnt - 3'd1;
            end
          end
          default: ;
        endcase
      end
      if (load) begin
        state   <= ST_SHIFT;
        phase   <= 1'b0;
        bit_idx <= '0;
        tx_sh   <= hold_data;
        rx_sh   <= '0;
        len_q   <= CNT_W'(csx_len_decode(cfg_len));
        wait_q  <= eff_wait;
      end
      if (force_high) begin
        sdo <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/csx_rx_hold.sv
module csx_rx_hold #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              word_done,
  input  logic [DATA_W-1:0] word_data,
  input  logic              rd_en,
  input  logic              irq_en,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_full,
  output logic              overrun,
  output logic              rx_irq
);

  logic take_word;
  logic lost_word;
  logic full_nxt;

  assign take_word = word_done && (!rx_full || rd_en);
  assign lost_word = word_done && rx_full && !rd_en;

  always_comb begin
    full_nxt = rx_full;
    if (rd_en) begin
      full_nxt = 1'b0;
    end
    if (take_word) begin
      full_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data <= '0;
      rx_full <= 1'b0;
      overrun <= 1'b0;
      rx_irq  <= 1'b0;
    end else begin
      rx_full <= full_nxt;
      rx_irq  <= full_nxt && irq_en;
      if (take_word) begin
        rx_data <= word_data;
      end
      if (soft_rst) begin
        overrun <= 1'b0;
      end else if (lost_word) begin
        overrun <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/csx_engine.sv
module csx_engine #(
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_tick,
  input  logic [2:0]        cfg_len,
  input  logic [1:0]        cfg_wait,
  input  logic              cfg_slave,
  input  logic              irq_en,
  input  logic              soft_rst,
  input  logic              force_high,
  input  logic              tx_wr,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              tx_empty,
  output logic              bus_idle,
  output logic              rx_full,
  output logic              overrun,
  output logic              rx_irq,
  output logic              sclk,
  output logic              sdo,
  input  logic              sdi
);

  logic [DATA_W-1:0] hold_data;
  logic [DATA_W-1:0] word_data;
  logic              load;
  logic              busy;
  logic              word_done;

  csx_tx_hold #(.DATA_W(DATA_W)) tx_hold_i (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .wr_en     (tx_wr),
    .wr_data   (tx_data),
    .load      (load),
    .busy      (busy),
    .hold_data (hold_data),
    .tx_empty  (tx_empty),
    .bus_idle  (bus_idle)
  );

  csx_shift_eng #(.DATA_W(DATA_W)) shift_i (
    .clk        (clk),
    .rst        (rst),
    .soft_rst   (soft_rst),
    .bit_tick   (bit_tick),
    .cfg_len    (cfg_len),
    .cfg_wait   (cfg_wait),
    .cfg_slave  (cfg_slave),
    .force_high (force_high),
    .hold_valid (!tx_empty),
    .hold_data  (hold_data),
    .sdi        (sdi),
    .load       (load),
    .busy       (busy),
    .sclk       (sclk),
    .sdo        (sdo),
    .word_done  (word_done),
    .word_data  (word_data)
  );

  csx_rx_hold #(.DATA_W(DATA_W)) rx_hold_i (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .word_done (word_done),
    .word_data (word_data),
    .rd_en     (rx_rd),
    .irq_en    (irq_en),
    .rx_data   (rx_data),
    .rx_full   (rx_full),
    .overrun   (overrun),
    .rx_irq    (rx_irq)
  );

endmodule

// File: rtl/csx_engine_chk.sv
module csx_engine_chk #(
  parameter int DATA_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_tick,
  input logic              soft_rst,
  input logic              force_high,
  input logic              tx_wr,
  input logic              rx_rd,
  input logic [DATA_W-1:0] rx_data,
  input logic              tx_empty,
  input logic              bus_idle,
  input logic              rx_full,
  input logic              overrun,
  input logic              rx_irq,
  input logic              sclk,
  input logic              sdo
);

  assert_sclk_paced_R2: assert property (@(posedge clk) disable iff (rst)
    (!bit_tick && !soft_rst) |=> $stable(sclk));

  assert_idle_clock_high_R2: assert property (@(posedge clk) disable iff (rst)
    bus_idle |-> sclk);

  assert_write_clears_empty_R6: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && tx_empty && !soft_rst) |=> !tx_empty);

  assert_write_clears_idle_R7: assert property (@(posedge clk) disable iff (rst)
    (tx_wr && tx_empty && !soft_rst) |=> !bus_idle);

  assert_irq_needs_full_R8: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> rx_full);

  assert_full_holds_data_R9: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !rx_rd) |=> $stable(rx_data));

  assert_overrun_when_full_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(overrun) |-> $past(rx_full));

  assert_force_drives_high_R10: assert property (@(posedge clk) disable iff (rst)
    force_high |=> sdo);

  assert_soft_reset_R11: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (sclk && tx_empty && bus_idle && !overrun));

endmodule

bind csx_engine csx_engine_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .bit_tick   (bit_tick),
  .soft_rst   (soft_rst),
  .force_high (force_high),
  .tx_wr      (tx_wr),
  .rx_rd      (rx_rd),
  .rx_data    (rx_data),
  .tx_empty   (tx_empty),
  .bus_idle   (bus_idle),
  .rx_full    (rx_full),
  .overrun    (overrun),
  .rx_irq     (rx_irq),
  .sclk       (sclk),
  .sdo        (sdo)
);

// File: tb/csx_engine_tb_top.sv
`timescale 1ns/1ps
module csx_engine_tb_top;

  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          bit_tick = 1'b0;
  logic [2:0]    cfg_len = 3'b000;
  logic [1:0]    cfg_wait = 2'd0;
  logic          cfg_slave = 1'b0;
  logic          irq_en = 1'b0;
  logic          soft_rst = 1'b0;
  logic          force_high = 1'b0;
  logic          tx_wr = 1'b0;
  logic [DW-1:0] tx_data = '0;
  logic          rx_rd = 1'b0;
  logic [DW-1:0] rx_data;
  logic          tx_empty, bus_idle, rx_full, overrun, rx_irq, sclk, sdo;
  logic          loop_sel = 1'b1;
  logic          sdi_val = 1'b0;
  logic          sdi;

  assign sdi = loop_sel ? sdo : sdi_val;

  always #2 clk = ~clk;

  csx_engine #(.DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .cfg_len(cfg_len),
    .cfg_wait(cfg_wait), .cfg_slave(cfg_slave), .irq_en(irq_en),
    .soft_rst(soft_rst), .force_high(force_high), .tx_wr(tx_wr),
    .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data),
    .tx_empty(tx_empty), .bus_idle(bus_idle), .rx_full(rx_full),
    .overrun(overrun), .rx_irq(rx_irq), .sclk(sclk), .sdo(sdo), .sdi(sdi)
  );

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  int            exp_len_q[$];
  logic [DW-1:0] exp_dat_q[$];
  int            mon_bits = 0;
  logic [DW-1:0] got = '0;
  logic          prev_sclk = 1'b1;
  bit            mon_hold = 1'b0;
  int            last_rise = 0;
  int            last_gap = 0;

  function automatic logic [DW-1:0] mask_of(input int len);
    return DW'((1 << len) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // Tick generator: one pulse every 4 clocks (a half-bit).
  initial begin
    int tc = 0;
    forever begin
      @(negedge clk);
      tc = (tc + 1) % 4;
      bit_tick = (tc == 3);
    end
  end

  // Monitor: collect sdo on each rising sclk and compare with the scoreboard.
  always @(negedge clk) begin
    if (sclk !== prev_sclk) begin
      if (sclk === 1'b1) begin
        last_rise = cyc;
        if (!mon_hold) begin
          if (exp_len_q.size() == 0) begin
            chk(1'b0, "R6 unexpected serial bit", int'(sdo), 0);
          end else begin
            if (mon_bits == 0) got = '0;
            got[mon_bits] = sdo;
            mon_bits++;
            if (mon_bits == exp_len_q[0]) begin
              chk(got == exp_dat_q[0], "R2 serial word LSB first", int'(got), int'(exp_dat_q[0]));
              void'(exp_len_q.pop_front());
              void'(exp_dat_q.pop_front());
              mon_bits = 0;
            end
          end
        end
      end else begin
        if (!mon_hold && mon_bits == 0) last_gap = cyc - last_rise;
      end
    end
    prev_sclk = sclk;
  end

  task automatic wr_raw(input logic [DW-1:0] d);
    @(negedge clk);
    tx_wr = 1'b1;
    tx_data = d;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic send(input logic [DW-1:0] d, input int len);
    exp_len_q.push_back(len);
    exp_dat_q.push_back(d & mask_of(len));
    wr_raw(d);
  endtask

  task automatic wait_empty();
    int n = 0;
    while (!tx_empty && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(1'b0, "R6 timeout on tx_empty", 0, 1);
  endtask

  task automatic wait_idle();
    int n = 0;
    while (!bus_idle && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk(1'b0, "R7 timeout on bus_idle", 0, 1);
  endtask

  task automatic rd_pulse();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic sreset();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    chk(sclk == 1'b1 && sdo == 1'b1, "R12 line idle high", {sclk, sdo}, 3);
    chk(tx_empty && bus_idle, "R12 transmit flags", {tx_empty, bus_idle}, 3);
    chk(!rx_full && !overrun && !rx_irq, "R12 receive flags", {rx_full, overrun, rx_irq}, 0);
    chk(rx_data == 0, "R12 rx_data", int'(rx_data), 0);

    // 8-bit word, loopback, interrupt enabled (R3, R8)
    irq_en = 1'b1;
    send(9'h0A5, 8);
    wait_idle();
    chk(rx_full && rx_irq, "R8 full and irq after word", {rx_full, rx_irq}, 3);
    chk(rx_data == 9'h0A5, "R3 rx_data 8-bit", int'(rx_data), 'h0A5);
    rd_pulse();
    chk(!rx_full && !rx_irq, "R8 read clears full and irq", {rx_full, rx_irq}, 0);

    // Length codes (R1, R3)
    for (int k = 1; k <= 4; k++) begin
      int ln;
      cfg_len = 3'(k);
      ln = (k == 4) ? 9 : k + 4;
      send(9'h1F3, ln);
      wait_idle();
      chk(rx_data == (9'h1F3 & mask_of(ln)), "R1 length code decode", int'(rx_data), int'(9'h1F3 & mask_of(ln)));
      rd_pulse();
    end

    // External input all ones, 5 bits, interrupt disabled (R3, R8)
    cfg_len = 3'b001;
    irq_en = 1'b0;
    loop_sel = 1'b0;
    sdi_val = 1'b1;
    send(9'h000, 5);
    wait_idle();
    chk(rx_data == 9'h01F, "R3 upper bits zero", int'(rx_data), 'h1F);
    chk(rx_full && !rx_irq, "R8 irq masked by enable", {rx_full, rx_irq}, 2);
    rd_pulse();
    loop_sel = 1'b1;

    // Gaps between back-to-back words (R4, R6, R7, R9, R11)
    cfg_len = 3'b000;
    for (int w = 0; w < 4; w++) begin
      if (w == 2) continue;
      cfg_wait = 2'(w);
      send(9'h03C, 8);
      wait_empty();
      chk(tx_empty && !bus_idle, "R7 empty but line busy", {tx_empty, bus_idle}, 2);
      send(9'h0C3, 8);
      wait_idle();
      chk(last_gap == 4 * (2 * w + 1), "R4 inter-word gap", last_gap, 4 * (2 * w + 1));
      chk(overrun && rx_data == 9'h03C, "R9 overrun keeps first word", {overrun, rx_data}, {1'b1, 9'h03C});
      sreset();
      chk(!overrun && rx_full, "R11 soft reset clears overrun only", {overrun, rx_full}, 1);
      rd_pulse();
    end

    // Slave forces zero gap (R5)
    cfg_slave = 1'b1;
    cfg_wait = 2'd3;
    send(9'h011, 8);
    wait_empty();
    send(9'h022, 8);
    wait_idle();
    chk(last_gap == 4, "R5 slave gap forced to zero", last_gap, 4);
    cfg_slave = 1'b0;
    cfg_wait = 2'd0;
    sreset();
    rd_pulse();

    // Ignored write while holding register full (R6)
    send(9'h055, 8);
    wait_empty();
    send(9'h066, 8);
    wr_raw(9'h077);
    chk(!tx_empty, "R6 write while full ignored", int'(tx_empty), 0);
    wait_idle();
    chk(exp_len_q.size() == 0, "R6 only accepted words sent", exp_len_q.size(), 0);
    sreset();
    rd_pulse();

    // Force high (R10)
    send(9'h000, 8);
    wait_idle();
    chk(sdo == 1'b0, "R10 line low after zero word", int'(sdo), 0);
    @(negedge clk); force_high = 1'b1;
    @(negedge clk); force_high = 1'b0;
    chk(sdo == 1'b1, "R10 force drives high", int'(sdo), 1);
    rd_pulse();

    // Soft reset in mid-word (R11)
    send(9'h0FF, 8);
    begin
      int n = 0;
      while (sclk && n < 200) begin @(negedge clk); n++; end
    end
    mon_hold = 1'b1;
    sreset();
    chk(sclk && tx_empty && bus_idle, "R11 abort state", {sclk, tx_empty, bus_idle}, 7);
    repeat (40) @(negedge clk);
    chk(sclk && !rx_full, "R11 no further transfer", {sclk, rx_full}, 2);
    exp_len_q.delete();
    exp_dat_q.delete();
    mon_bits = 0;
    mon_hold = 1'b0;

    finish_run();
  end

endmodule